// File: doc/BRIEF.md
# Peak Current Mode PWM Controller

This block is the digital timing and gating core of a boost converter run in peak current mode. A free-running phase counter splits each switching period into a charge phase and a shorter discharge phase. The power switch is turned on as each period begins. It is turned off as soon as a synchronized comparator flag reports that the sensed inductor current has crossed the error level. A separate current-limit flag and the end of the charge phase also turn it off. Once off, the switch stays off until the next period begins.

A shutdown input stops switching within a few cycles of being raised. Lowering it has no effect until the next period boundary, so a partial first pulse cannot occur. The block also produces the select line that steers the external error path to one of two feedback dividers. The select pin's input is modelled as a driver-present bit and a level bit, so that an undriven pin selects the second divider.

Top module: `pcm_pwm_ctrl`

## Requirements
- R1: While rst_ni is low, sw_on_o is 0, cyc_start_o is 1, charge_o is 1 and fb_sel_o is 1. In the first period after reset release, sw_on_o stays 0 for all PERIOD cycles.
- R2: The phase count runs 0..PERIOD-1 and wraps. cyc_start_o is 1 only at count 0. charge_o is 1 exactly for counts 0..CHARGE-1.
- R3: When shutdown is not active, sw_on_o is 1 at count 0 of every period.
- R4: sw_on_o is 0 for counts CHARGE..PERIOD-1, so the on-time is at most CHARGE cycles per period (85% with the defaults).
- R5: Each asynchronous input passes through a two-flop synchronizer. A one-cycle pulse on cmp_trip_i driven while the count is t turns sw_on_o off from count t+3. The on-time becomes min(t+3, CHARGE).
- R6: After a trip, sw_on_o stays 0 for the rest of the period, even when the comparator input falls again. sw_on_o only rises at count 0. A trip still pending in the synchronizer at a wrap cuts the next pulse short.
- R7: A pulse on ilim_i has the same effect and timing as a pulse on cmp_trip_i, independently of it.
- R8: shdn_i high, sampled while the count is s, forces sw_on_o to 0 from count s+3. It keeps sw_on_o at 0 for every later period while it stays high.
- R9: Lowering shdn_i at count c with c <= PERIOD-3 gives a full CHARGE-cycle pulse in the next period. Lowering it at count PERIOD-2 or later skips one more whole period.
- R10: fb_sel_o = 0 (first feedback path) only when sel_drv_i = 1 and sel_lvl_i = 0. Otherwise it is 1 (second path). It follows its inputs two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shdn_i | input | 1 | Switching shutdown, active high, asynchronous |
| cmp_trip_i | input | 1 | Current-sense comparator flag, asynchronous |
| ilim_i | input | 1 | Current-limit flag, asynchronous |
| sel_drv_i | input | 1 | 1 when the feedback-select pin is actively driven |
| sel_lvl_i | input | 1 | Level on the feedback-select pin when driven |
| sw_on_o | output | 1 | Power switch gate command |
| cyc_start_o | output | 1 | High during count 0 of each period |
| charge_o | output | 1 | High during the charge phase of the ramp |
| fb_sel_o | output | 1 | Feedback path select: 0 first, 1 second |

## Verification
Every asynchronous input takes two edges to cross the synchronizer. The switch register needs one more edge, so a trip, limit or shutdown applied at count t shows on sw_on_o at count t+3. The select output shows the pin state two cycles after it changes. The bench drives inputs on falling edges and indexes every sample by the phase count, which it recovers from cyc_start_o. It measures the on-time of whole periods and compares each with min(t+3, CHARGE) or with the period-boundary rule for shutdown. Select checks are taken two falling edges after the change.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  // synchronizer lane map
  localparam int unsigned SY_TRIP = 0;
  localparam int unsigned SY_ILIM = 1;
  localparam int unsigned SY_SHDN = 2;
  localparam int unsigned SY_DRV  = 3;
  localparam int unsigned SY_LVL  = 4;
  localparam int unsigned SY_W    = 5;

  typedef enum logic [0:0] {FB_FIRST = 1'b0, FB_SECOND = 1'b1} fb_path_e;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pcm_osc.sv
module pcm_osc #(
  parameter int unsigned PERIOD = 20,
  parameter int unsigned CHARGE = 17,
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o,
  output logic             cyc_start_o,
  output logic             charge_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] CHG  = CNT_W'(CHARGE);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o    = (cnt_q == LAST);
  assign cnt_nxt_o = wrap_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;

  assign cyc_start_o = (cnt_q == '0);
  assign charge_o    = (cnt_q < CHG);
endmodule

// File: rtl/pcm_gate.sv
module pcm_gate #(
  parameter int unsigned PERIOD = 20,
  parameter int unsigned CHARGE = 17,
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             trip_i,
  input  logic             ilim_i,
  input  logic             shdn_i,
  output logic             sw_o
);
  localparam logic [CNT_W-1:0] CHG = CNT_W'(CHARGE);

  logic sw_q, sw_d, keep;

  // off-state is sticky: only a period boundary can set the switch
  assign keep = sw_q & ~trip_i & ~ilim_i & (cnt_nxt_i < CHG);

  always_comb begin
    if (shdn_i)      sw_d = 1'b0;
    else if (wrap_i) sw_d = 1'b1;
    else             sw_d = keep;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sw_q <= 1'b0;
    else         sw_q <= sw_d;

  assign sw_o = sw_q;
endmodule

// File: rtl/pcm_pwm_ctrl.sv
module pcm_pwm_ctrl
  import pcm_pkg::*;
#(
  parameter int unsigned PERIOD      = 20,
  parameter int unsigned CHARGE      = 17,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shdn_i,
  input  logic cmp_trip_i,
  input  logic ilim_i,
  input  logic sel_drv_i,
  input  logic sel_lvl_i,
  output logic sw_on_o,
  output logic cyc_start_o,
  output logic charge_o,
  output logic fb_sel_o
);
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  // undriven select pin must read as second path out of reset
  localparam logic [SY_W-1:0] SY_RST = SY_W'(1) << SY_LVL;

  logic [SY_W-1:0]  raw, syn;
  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap;
  fb_path_e         path;

  assign raw[SY_TRIP] = cmp_trip_i;
  assign raw[SY_ILIM] = ilim_i;
  assign raw[SY_SHDN] = shdn_i;
  assign raw[SY_DRV]  = sel_drv_i;
  assign raw[SY_LVL]  = sel_lvl_i;

  pcm_sync #(.W(SY_W), .STAGES(SYNC_STAGES), .RST_VAL(SY_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  pcm_osc #(.PERIOD(PERIOD), .CHARGE(CHARGE)) u_osc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_nxt_o  (cnt_nxt),
    .wrap_o     (wrap),
    .cyc_start_o(cyc_start_o),
    .charge_o   (charge_o)
  );

  pcm_gate #(.PERIOD(PERIOD), .CHARGE(CHARGE)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap),
    .cnt_nxt_i(cnt_nxt),
    .trip_i   (syn[SY_TRIP]),
    .ilim_i   (syn[SY_ILIM]),
    .shdn_i   (syn[SY_SHDN]),
    .sw_o     (sw_on_o)
  );

  assign path     = (syn[SY_DRV] && !syn[SY_LVL]) ? FB_FIRST : FB_SECOND;
  assign fb_sel_o = path;
endmodule

// File: rtl/pcm_pwm_ctrl_chk.sv
module pcm_pwm_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic shdn_i,
  input logic cmp_trip_i,
  input logic ilim_i,
  input logic sel_drv_i,
  input logic sel_lvl_i,
  input logic sw_on_o,
  input logic cyc_start_o,
  input logic charge_o,
  input logic fb_sel_o
);
  logic [1:0] warm_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;

  assign warm = (warm_q == 2'd3);

  p_rise_at_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_on_o) |-> cyc_start_o);

  p_discharge_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !charge_o |-> !sw_on_o);

  p_trip_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(cmp_trip_i, 3) && !cyc_start_o) |-> !sw_on_o);

  p_ilim_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(ilim_i, 3) && !cyc_start_o) |-> !sw_on_o);

  p_shdn_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(shdn_i, 3)) |-> !sw_on_o);

  p_fb_sel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (fb_sel_o == ($past(!sel_drv_i, 2) || $past(sel_lvl_i, 2))));

  p_start_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |=> !cyc_start_o);
endmodule

bind pcm_pwm_ctrl pcm_pwm_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shdn_i     (shdn_i),
  .cmp_trip_i (cmp_trip_i),
  .ilim_i     (ilim_i),
  .sel_drv_i  (sel_drv_i),
  .sel_lvl_i  (sel_lvl_i),
  .sw_on_o    (sw_on_o),
  .cyc_start_o(cyc_start_o),
  .charge_o   (charge_o),
  .fb_sel_o   (fb_sel_o)
);

// File: tb/sim_pcm_pwm_ctrl.sv
`timescale 1ns/1ps
module sim_pcm_pwm_ctrl;
  localparam int P = 20;
  localparam int C = 17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic shdn = 1'b0, trip = 1'b0, ilim = 1'b0, drv = 1'b0, lvl = 1'b0;
  logic sw, cst, chg, fbs;
  int   n_chk = 0, n_err = 0;
  int   shdn_set_at = -1, shdn_clr_at = -1;

  always #5 clk = ~clk;

  pcm_pwm_ctrl #(.PERIOD(P), .CHARGE(C)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .shdn_i(shdn), .cmp_trip_i(trip),
    .ilim_i(ilim), .sel_drv_i(drv), .sel_lvl_i(lvl),
    .sw_on_o(sw), .cyc_start_o(cst), .charge_o(chg), .fb_sel_o(fbs)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge with the count at 0; returns at count 0 of the next period
  task automatic run_period(input int trip_at, input int lim_at,
                            output int on_n, output int rises,
                            output int chg_n, output int st_n);
    int prev = 0;
    on_n = 0; rises = 0; chg_n = 0; st_n = 0;
    for (int c = 0; c < P; c++) begin
      if (sw) on_n++;
      if (c > 0 && sw && !prev) rises++;
      prev = int'(sw);
      if (chg) chg_n++;
      if (cst && c == 0) st_n++;
      if (cst && c != 0) st_n += 100;
      if (!chg && sw) on_n += 1000;
      trip = (c == trip_at);
      ilim = (c == lim_at);
      if (c == shdn_set_at) shdn = 1'b1;
      if (c == shdn_clr_at) shdn = 1'b0;
      @(negedge clk);
    end
    shdn_set_at = -1; shdn_clr_at = -1;
  endtask

  task automatic sel_case(input logic d, input logic l, input int exp);
    drv = d; lvl = l;
    @(negedge clk); @(negedge clk);
    check("R10", int'(fbs), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int on_n, rs, cg, st;
    repeat (3) @(negedge clk);
    check("R1", int'(sw), 0);
    check("R1", int'(cst), 1);
    check("R1", int'(chg), 1);
    check("R1", int'(fbs), 1);
    rst_n = 1'b1;
    run_period(-1, -1, on_n, rs, cg, st);
    check("R1", on_n, 0);
    // free-running periods: full on-time, phase markers
    for (int k = 0; k < 3; k++) begin
      run_period(-1, -1, on_n, rs, cg, st);
      check("R3", on_n, C);
      check("R4", rs, 0);
      check("R2", cg, C);
      check("R2", st, 1);
    end
    // comparator trip sweep across the period
    for (int t = 0; t <= P - 4; t++) begin
      run_period(t, -1, on_n, rs, cg, st);
      check("R5", on_n, (t + 3 < C) ? t + 3 : C);
      check("R6", rs, 0);
      run_period(-1, -1, on_n, rs, cg, st);
      check("R3", on_n, C);
    end
    // trip pending across the wrap
    run_period(P - 1, -1, on_n, rs, cg, st);
    check("R6", on_n, C);
    run_period(-1, -1, on_n, rs, cg, st);
    check("R6", on_n, 2);
    run_period(-1, -1, on_n, rs, cg, st);
    check("R6", on_n, C);
    // current limit sweep
    for (int t = 0; t <= P - 4; t += 3) begin
      run_period(-1, t, on_n, rs, cg, st);
      check("R7", on_n, (t + 3 < C) ? t + 3 : C);
      check("R7", rs, 0);
    end
    // shutdown entry mid-pulse, hold, late release
    shdn_set_at = 5;
    run_period(-1, -1, on_n, rs, cg, st);
    check("R8", on_n, 8);
    run_period(-1, -1, on_n, rs, cg, st);
    check("R8", on_n, 0);
    shdn_clr_at = P - 2;
    run_period(-1, -1, on_n, rs, cg, st);
    check("R8", on_n, 0);
    run_period(-1, -1, on_n, rs, cg, st);
    check("R9", on_n, 0);
    run_period(-1, -1, on_n, rs, cg, st);
    check("R9", on_n, C);
    // release at the last count that still counts for the next period
    shdn_set_at = 0;
    run_period(-1, -1, on_n, rs, cg, st);
    check("R8", on_n, 3);
    shdn_clr_at = P - 3;
    run_period(-1, -1, on_n, rs, cg, st);
    check("R9", on_n, 0);
    run_period(-1, -1, on_n, rs, cg, st);
    check("R9", on_n, C);
    // release early in a period
    shdn_set_at = 1;
    run_period(-1, -1, on_n, rs, cg, st);
    check("R8", on_n, 4);
    shdn_clr_at = 2;
    run_period(-1, -1, on_n, rs, cg, st);
    check("R9", on_n, 0);
    run_period(-1, -1, on_n, rs, cg, st);
    check("R9", on_n, C);
    // feedback select, all pin states
    sel_case(1'b0, 1'b0, 1);
    sel_case(1'b1, 1'b0, 0);
    sel_case(1'b1, 1'b1, 1);
    sel_case(1'b0, 1'b1, 1);
    sel_case(1'b1, 1'b0, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule